// File: doc/BRIEF.md
# Configurable PWM Channel Generator

This block produces one pulse-width-modulated output from a master clock. The counting rate is derived in two stages: a power-of-two prescaler that divides the master clock by 1 up to 1024, optionally followed by one of two programmable linear dividers. A period counter runs at this channel rate and is compared against a programmed period and a programmed duty threshold. The output holds a selectable start level while the counter is below the duty threshold and the opposite level for the rest of the period.

Two alignments are supported. In left-aligned mode the counter ramps up and wraps. In center-aligned mode it ramps up and then back down, which doubles the period and places the active pulse symmetrically around the middle of it. This lets several channels with different duty values avoid overlapping edges. An end-of-period strobe marks the last master-clock cycle of every period.

Configuration written while the channel runs is held back and applied at the next period boundary, so a period is never cut short and never stretched. While the channel is disabled, the configuration is taken in continuously and the counters rest at zero.

Top module: `pwm_channel`

## Requirements
- R1: With `cfg_src` set to 0 or 3, the channel rate is the master clock divided by X = 2^`cfg_sel`. A `cfg_sel` value above 10 acts as 10, so X = 1024.
- R2: `cfg_src` = 1 further divides the prescaled rate by `cfg_div_a`, and `cfg_src` = 2 by `cfg_div_b`. A divider value of 0 acts as 1.
- R3: In left-aligned mode (`cfg_center` = 0) a period lasts X × D × P master cycles. D is the active linear divider (1 when none is selected) and P is `cfg_period`, with 0 acting as 1.
- R4: In center-aligned mode (`cfg_center` = 1) a period lasts 2 × X × D × P master cycles.
- R5: In each period the output sits at the start level for X × D × min(`cfg_duty`, P) cycles, doubled in center-aligned mode, and at the opposite level otherwise.
- R6: `cfg_pol` = 0 makes the start level low and `cfg_pol` = 1 makes it high; every period opens at the start level when `cfg_duty` > 0.
- R7: While `en` is low, `pwm_out` equals `cfg_pol`, `period_end` stays low and the counters rest at zero, so the first period after enabling has its full length.
- R8: While enabled, configuration changes take effect only at a period boundary. The value present during the `period_end` cycle is the one used for the next period.
- R9: `period_end` is high for exactly one master cycle, the last cycle of each period.
- R10: After reset, with `en` low, `period_end` is low and `pwm_out` follows `cfg_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| cfg_sel | input | 4 | Prescaler exponent, X = 2^min(value,10) |
| cfg_src | input | 2 | Rate source: 0/3 prescaler only, 1 linear divider A, 2 linear divider B |
| cfg_div_a | input | 8 | Linear divider A (0 acts as 1) |
| cfg_div_b | input | 8 | Linear divider B (0 acts as 1) |
| cfg_period | input | 16 | Period length in channel ticks (0 acts as 1) |
| cfg_duty | input | 16 | Duty threshold in channel ticks |
| cfg_pol | input | 1 | Start level of each period |
| cfg_center | input | 1 | 1 selects center alignment |
| pwm_out | output | 1 | PWM waveform |
| period_end | output | 1 | One-cycle strobe in the last cycle of each period |

## Verification
A configuration write can land in the same cycle as a period boundary, where the running configuration is reloaded. The bench provokes this by changing the period while `period_end` is high. It expects the following period to already use the new value. A write one cycle later must leave the next period at the old length, and only the period after that may change. Both cases are judged by counting master cycles between consecutive `period_end` strobes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PRD_W       = 16;
    localparam int DIV_W       = 8;
    localparam int SEL_W       = 4;
    localparam int PRE_LOG_MAX = 10;
    localparam int SRC_W       = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_PRE     = 2'd0,
        SRC_LIN_A   = 2'd1,
        SRC_LIN_B   = 2'd2,
        SRC_PRE_ALT = 2'd3
    } clk_src_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic [PRD_W-1:0] prd;
        logic [PRD_W-1:0] dty;
        logic [DIV_W-1:0] div_a;
        logic [DIV_W-1:0] div_b;
        logic [SEL_W-1:0] sel;
        clk_src_e         src;
        logic             pol;
        logic             center;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{
        prd: PRD_W'(1), dty: '0, div_a: DIV_W'(1), div_b: DIV_W'(1),
        sel: '0, src: SRC_PRE, pol: 1'b0, center: 1'b0
    };

    function automatic logic uses_linear(input clk_src_e s);
        return (s == SRC_LIN_A) || (s == SRC_LIN_B);
    endfunction

    function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] s);
        return (s > SEL_W'(PRE_LOG_MAX)) ? SEL_W'(PRE_LOG_MAX) : s;
    endfunction

    function automatic logic [DIV_W-1:0] pick_div(input chan_cfg_t c);
        logic [DIV_W-1:0] d;
        d = (c.src == SRC_LIN_B) ? c.div_b : c.div_a;
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    function automatic logic [PRD_W-1:0] eff_prd(input logic [PRD_W-1:0] p);
        return (p == '0) ? PRD_W'(1) : p;
    endfunction

endpackage

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  clk_src_e         src,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PRE_W = PRE_LOG_MAX;

    logic [SEL_W-1:0] sel_c;
    logic [PRE_W-1:0] pre_lim;
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_tick;
    logic             lin;
    logic             div_last;

    assign sel_c = clamp_sel(sel);

    // limit = 2^sel - 1: low sel bits set
    for (genvar i = 0; i < PRE_W; i++) begin : g_lim
        assign pre_lim[i] = (SEL_W'(i) < sel_c);
    end

    assign lin      = uses_linear(src);
    assign pre_tick = run && (pre_cnt == pre_lim);
    assign div_last = (div_cnt == div - DIV_W'(1));
    assign tick     = pre_tick && (!lin || div_last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_tick) begin
            pre_cnt <= '0;
            if (lin) begin
                div_cnt <= div_last ? '0 : div_cnt + DIV_W'(1);
            end
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [PRD_W-1:0] prd,
    input  logic             center,
    output logic [PRD_W-1:0] cnt,
    output logic             boundary
);
    dir_e dir;
    logic at_top;

    assign at_top   = (cnt == prd - PRD_W'(1));
    assign boundary = tick && (center ? (dir == DIR_DOWN && cnt == '0) : at_top);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (tick) begin
            if (center) begin
                if (dir == DIR_UP) begin
                    if (at_top) dir <= DIR_DOWN;   // top value held for two ticks
                    else        cnt <= cnt + PRD_W'(1);
                end else begin
                    if (cnt == '0) dir <= DIR_UP;  // zero held across the boundary
                    else           cnt <= cnt - PRD_W'(1);
                end
            end else begin
                cnt <= at_top ? '0 : cnt + PRD_W'(1);
                dir <= DIR_UP;
            end
        end
    end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_pkg::*;
(
    input  logic             run,
    input  logic [PRD_W-1:0] cnt,
    input  logic [PRD_W-1:0] dty,
    input  logic             pol,
    input  logic             idle_pol,
    output logic             wave
);
    always_comb begin
        if (!run)            wave = idle_pol;
        else if (cnt < dty)  wave = pol;
        else                 wave = ~pol;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [3:0]       cfg_sel,
    input  logic [1:0]       cfg_src,
    input  logic [7:0]       cfg_div_a,
    input  logic [7:0]       cfg_div_b,
    input  logic [15:0]      cfg_period,
    input  logic [15:0]      cfg_duty,
    input  logic             cfg_pol,
    input  logic             cfg_center,
    output logic             pwm_out,
    output logic             period_end
);
    chan_cfg_t        req;
    chan_cfg_t        act;
    logic [PRD_W-1:0] prd_eff;
    logic [DIV_W-1:0] div_eff;
    logic [PRD_W-1:0] cnt_q;
    logic             tick;
    logic             boundary;

    always_comb begin
        req        = CFG_RESET;
        req.prd    = cfg_period;
        req.dty    = cfg_duty;
        req.div_a  = cfg_div_a;
        req.div_b  = cfg_div_b;
        req.sel    = cfg_sel;
        req.src    = clk_src_e'(cfg_src);
        req.pol    = cfg_pol;
        req.center = cfg_center;
    end

    // shadow: follows the request while idle, reloads at each boundary
    always_ff @(posedge clk) begin
        if (rst)                 act <= CFG_RESET;
        else if (!en || boundary) act <= req;
    end

    assign prd_eff = eff_prd(act.prd);
    assign div_eff = pick_div(act);

    pwm_clkgen u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (en),
        .sel  (act.sel),
        .src  (act.src),
        .div  (div_eff),
        .tick (tick)
    );

    pwm_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .tick     (tick),
        .prd      (prd_eff),
        .center   (act.center),
        .cnt      (cnt_q),
        .boundary (boundary)
    );

    pwm_compare u_compare (
        .run      (en),
        .cnt      (cnt_q),
        .dty      (act.dty),
        .pol      (act.pol),
        .idle_pol (cfg_pol),
        .wave     (pwm_out)
    );

    assign period_end = boundary;

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk
    import pwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             period_end,
    input logic [PRD_W-1:0] cnt,
    input logic [PRD_W-1:0] prd_eff,
    input logic [PRD_W-1:0] act_prd,
    input logic [PRD_W-1:0] act_dty
);
    // R7: no strobe while disabled
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !en |-> !period_end);

    // R7: counter rests at zero after a disabled cycle
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

    // R3: counter never leaves the programmed range
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < prd_eff);

    // R8: running configuration only moves after a boundary
    assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && !$past(period_end)) |->
            ($stable(act_prd) && $stable(act_dty)));
endmodule

bind pwm_channel pwm_channel_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .period_end (period_end),
    .cnt        (cnt_q),
    .prd_eff    (prd_eff),
    .act_prd    (act.prd),
    .act_dty    (act.dty)
);

// File: tb/test_pwm_channel.sv
module test_pwm_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [1:0]  cfg_src = '0;
    logic [7:0]  cfg_div_a = 8'd1;
    logic [7:0]  cfg_div_b = 8'd1;
    logic [15:0] cfg_period = 16'd1;
    logic [15:0] cfg_duty = '0;
    logic        cfg_pol = 1'b0;
    logic        cfg_center = 1'b0;
    logic        pwm_out;
    logic        period_end;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_channel i_pwm_channel (
        .clk(clk), .rst(rst), .en(en),
        .cfg_sel(cfg_sel), .cfg_src(cfg_src),
        .cfg_div_a(cfg_div_a), .cfg_div_b(cfg_div_b),
        .cfg_period(cfg_period), .cfg_duty(cfg_duty),
        .cfg_pol(cfg_pol), .cfg_center(cfg_center),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint f_scale(input int sel, input int src, input int da, input int db);
        longint x, d;
        x = longint'(1) << ((sel > 10) ? 10 : sel);
        d = 1;
        if (src == 1) d = (da == 0) ? 1 : da;
        if (src == 2) d = (db == 0) ? 1 : db;
        return x * d;
    endfunction

    function automatic longint f_period(input int sel, input int src, input int da, input int db,
                                        input int prd, input bit ctr);
        longint p;
        p = (prd == 0) ? 1 : prd;
        return f_scale(sel, src, da, db) * p * (ctr ? 2 : 1);
    endfunction

    function automatic longint f_start(input int sel, input int src, input int da, input int db,
                                       input int prd, input int dty, input bit ctr);
        longint p, m;
        p = (prd == 0) ? 1 : prd;
        m = (dty < p) ? dty : p;
        return f_scale(sel, src, da, db) * m * (ctr ? 2 : 1);
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // counts cycles up to and including the next strobe
    task automatic measure(output longint len, output longint st);
        bit fin;
        len = 0; st = 0; fin = 0;
        while (!fin) begin
            len++;
            if (pwm_out == cfg_pol) st++;
            if (period_end) fin = 1;
            else step();
        end
    endtask

    task automatic setup(input int sel, input int src, input int da, input int db,
                         input int prd, input int dty, input bit pol, input bit ctr);
        en = 1'b0;
        step();
        cfg_sel = 4'(sel); cfg_src = 2'(src);
        cfg_div_a = 8'(da); cfg_div_b = 8'(db);
        cfg_period = 16'(prd); cfg_duty = 16'(dty);
        cfg_pol = pol; cfg_center = ctr;
        step();
        step();
        @(negedge clk);
        en = 1'b1;
        #1;
    endtask

    task automatic run_case(input int sel, input int src, input int da, input int db,
                            input int prd, input int dty, input bit pol, input bit ctr);
        longint ep, es, len, st;
        string ptag;
        ep = f_period(sel, src, da, db, prd, ctr);
        es = f_start(sel, src, da, db, prd, dty, ctr);
        if (ctr)                       ptag = "R4 period";
        else if (src == 1 || src == 2) ptag = "R2 period";
        else if (sel > 0)              ptag = "R1 period";
        else                           ptag = "R3 period";
        setup(sel, src, da, db, prd, dty, pol, ctr);
        if (dty > 0) chk(pwm_out == pol, "R6 opening level", longint'(pwm_out), longint'(pol));
        for (int k = 0; k < 2; k++) begin
            measure(len, st);
            chk(len == ep, ptag, len, ep);
            chk(st == es, "R5 start-level cycles", st, es);
            step();
            if (ep > 1) chk(period_end == 1'b0, "R9 strobe width", longint'(period_end), 0);
        end
        en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        longint len, st;
        int pulses;
        void'($urandom(32'd4242));

        repeat (3) step();
        rst = 1'b0;
        step();
        // R10 reset state
        chk(period_end == 1'b0, "R10 strobe after reset", longint'(period_end), 0);
        chk(pwm_out == 1'b0, "R10 output after reset", longint'(pwm_out), 0);

        // R7 idle behaviour
        cfg_pol = 1'b1;
        #1;
        chk(pwm_out == 1'b1, "R7 idle level high", longint'(pwm_out), 1);
        cfg_pol = 1'b0;
        #1;
        chk(pwm_out == 1'b0, "R7 idle level low", longint'(pwm_out), 0);
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            if (period_end) pulses++;
            step();
        end
        chk(pulses == 0, "R7 no strobe while idle", pulses, 0);

        // directed corners
        run_case(0, 0, 1, 1, 5, 2, 0, 0);    // R3 plain
        run_case(0, 0, 1, 1, 0, 1, 1, 0);    // R3 period zero acts as one
        run_case(3, 0, 1, 1, 4, 4, 1, 0);    // R1 duty == period
        run_case(12, 0, 1, 1, 1, 0, 0, 0);   // R1 clamp to 1024, duty zero
        run_case(10, 3, 1, 1, 2, 1, 1, 1);   // R1 source code 3, R4
        run_case(1, 1, 0, 7, 3, 9, 0, 0);    // R2 div A zero acts as one, duty > period
        run_case(2, 2, 5, 3, 6, 3, 1, 1);    // R2 div B, R4 center
        run_case(0, 0, 1, 1, 1, 1, 0, 1);    // R4 smallest center period

        // R8: config write in the boundary cycle versus one cycle later
        setup(0, 0, 1, 1, 5, 2, 0, 0);
        measure(len, st);
        chk(len == 5, "R8 initial period", len, 5);
        cfg_period = 16'd9;
        step();
        measure(len, st);
        chk(len == 9, "R8 write at boundary applies", len, 9);
        step();
        cfg_period = 16'd3;
        measure(len, st);
        chk(len == 9, "R8 late write deferred", len, 9);
        step();
        measure(len, st);
        chk(len == 3, "R8 deferred write applies", len, 3);
        en = 1'b0;
        step();
        chk(period_end == 1'b0, "R7 strobe gone after disable", longint'(period_end), 0);

        // R7: first period after re-enable is full length
        setup(1, 0, 1, 1, 4, 1, 0, 0);
        measure(len, st);
        chk(len == 8, "R7 full first period", len, 8);
        en = 1'b0;

        // constrained random
        for (int n = 0; n < 20; n++) begin
            int sel, src, da, db, prd, dty;
            bit pol, ctr;
            sel = int'($urandom % 5);
            src = int'($urandom % 4);
            da  = int'($urandom % 5);
            db  = int'($urandom % 5);
            prd = int'($urandom % 11);
            dty = int'($urandom % 13);
            pol = 1'($urandom % 2);
            ctr = 1'($urandom % 2);
            run_case(sel, src, da, db, prd, dty, pol, ctr);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule